// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the status byte of a serial nonvolatile memory and decides, cycle by cycle, whether a write to the storage array or to the status byte itself may go ahead. It holds a lock-enable bit, a two-bit protection level, the write-enable latch and, via an input, the busy flag. The command decoder around it sends one-cycle pulses for write-enable, write-disable and write-completion. It also delivers the status data byte in two steps: an arm pulse when the byte has been received, and a commit pulse when the internal write starts.

The protection level fences off the top quarter, the top half or the whole address space. The address width is a parameter, so the ranges scale with it. The external active-low lock pin takes part only when the lock-enable bit is set, and then it guards only the status byte. Values that would be kept in nonvolatile cells are modelled as reset parameters.

Top module: `sr_status_guard`

## Requirements
- R1: After reset `status_o` shows bit 7 = RST_LOCK_EN, bits 3:2 = RST_LVL, bit 1 = 0 and bit 0 = `busy_i`. With the defaults and `busy_i` low this is 0x00.
- R2: The layout of `status_o` is: bit 7 lock-enable, bits 6:4 always 0, bits 3:2 protection level, bit 1 write-enable latch, bit 0 equal to `busy_i` in the same cycle.
- R3: A `wel_set_i` pulse sets the latch from the next cycle on, and a `wel_clr_i` pulse clears it. If a set coincides with a clear or with `wr_done_i`, the clear wins.
- R4: A `wr_done_i` pulse clears the latch on the next cycle, even while `busy_i` is high.
- R5: While `busy_i` is high, `wel_set_i`, `wel_clr_i` and `sr_arm_i` have no effect.
- R6: A commit updates only bits 7, 3 and 2, taking them from the armed byte. It takes effect on the next cycle, and only when a status write is pending and `sr_wr_ok_o` is 1. Each commit ends the pending state.
- R7: `sr_wr_ok_o` = latch AND NOT (lock-enable AND `lock_pin_ni` low). When lock-enable is 0 the pin has no effect.
- R8: If the lock becomes active while a status write is pending, that write is dropped. Releasing the pin before the commit does not bring it back.
- R9: With level 01 the addresses whose two top bits are 11 are protected. With level 10 those whose top bit is 1 are protected. With level 11 every address is protected. Level 00 protects none.
- R10: `arr_wr_ok_o` = latch AND NOT protected(`addr_i`), whatever the pin or lock-enable.
- R11: A commit with no pending status write leaves bits 7, 3 and 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_pin_ni | input | 1 | External write-lock pin, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| wel_set_i | input | 1 | Write-enable command pulse |
| wel_clr_i | input | 1 | Write-disable command pulse |
| wr_done_i | input | 1 | Array or status write completed |
| sr_arm_i | input | 1 | Status data byte received |
| sr_data_i | input | 8 | Status data byte |
| sr_commit_i | input | 1 | Internal status write starts |
| addr_i | input | AW | Array address under test |
| status_o | output | 8 | Readable status byte |
| sr_wr_ok_o | output | 1 | Status write permitted |
| arr_wr_ok_o | output | 1 | Array write to `addr_i` permitted |

## Verification
Several latch events can land in the same cycle. A write-enable pulse can meet a write-disable pulse or a completion pulse, and both meetings are provoked by driving the two pulses in one cycle. The latch must then read 0, which shows that clearing has priority. A second collision is a pending status write meeting a drop of the lock pin before the commit. The pin is dropped and then raised again ahead of the commit, and the bench judges the result by an unchanged status byte.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_e;

  localparam int unsigned LOCK_BIT = 7;
  localparam int unsigned LVL_HI   = 3;
  localparam int unsigned LVL_LO   = 2;
  localparam int unsigned WEL_BIT  = 1;
  localparam int unsigned BUSY_BIT = 0;
endpackage

// File: rtl/sr_prot_decode.sv
module sr_prot_decode
  import sr_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  prot_lvl_e       lvl_i,
  input  logic [AW-1:0]   addr_i,
  output logic            hit_o
);
  logic top_q, top_h;

  generate
    if (AW >= 2) begin : g_wide
      assign top_h = addr_i[AW-1];
      assign top_q = &addr_i[AW-1:AW-2];
    end else begin : g_narrow
      assign top_h = addr_i[AW-1];
      assign top_q = addr_i[AW-1];
    end
  endgenerate

  always_comb begin
    unique case (lvl_i)
      PROT_QTR:  hit_o = top_q;
      PROT_HALF: hit_o = top_h;
      PROT_ALL:  hit_o = 1'b1;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic done_i,
  input  logic hold_i,
  output logic wel_o
);
  logic set_ok, clr_ok;

  assign set_ok = set_i & ~hold_i;
  assign clr_ok = (clr_i & ~hold_i) | done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wel_o <= 1'b0;
    else if (clr_ok) wel_o <= 1'b0;
    else if (set_ok) wel_o <= 1'b1;
  end

  AST_WEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !hold_i && !clr_i && !done_i |=> wel_o);  // R3
  AST_WEL_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i || (clr_i && !hold_i) |=> !wel_o);  // R4
  AST_BUSY_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !wel_o |=> !wel_o);  // R5
endmodule

// File: rtl/sr_cfg_reg.sv
module sr_cfg_reg
  import sr_pkg::*;
#(
  parameter logic      RST_LOCK_EN = 1'b0,
  parameter prot_lvl_e RST_LVL     = PROT_NONE
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      arm_i,
  input  logic      hold_i,
  input  logic      lock_d_i,
  input  prot_lvl_e lvl_d_i,
  input  logic      commit_i,
  input  logic      wr_ok_i,
  input  logic      locked_i,
  output logic      lock_en_o,
  output prot_lvl_e lvl_o
);
  logic      pend_q;
  logic      pend_lock_q;
  prot_lvl_e pend_lvl_q;
  logic      do_wr;

  assign do_wr = commit_i & pend_q & wr_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_lock_q <= 1'b0;
      pend_lvl_q  <= PROT_NONE;
    end else if (commit_i || (pend_q && locked_i)) begin
      pend_q <= 1'b0;
    end else if (arm_i && !hold_i) begin
      pend_q      <= 1'b1;
      pend_lock_q <= lock_d_i;
      pend_lvl_q  <= lvl_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_en_o <= RST_LOCK_EN;
      lvl_o     <= RST_LVL;
    end else if (do_wr) begin
      lock_en_o <= pend_lock_q;
      lvl_o     <= pend_lvl_q;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable({lock_en_o, lvl_o}));  // R6
  AST_LOCKED_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !wr_ok_i |=> $stable({lock_en_o, lvl_o}));  // R7
  AST_ABORT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && locked_i && !commit_i |=> !pend_q);  // R8
  AST_NO_PEND_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !pend_q |=> $stable({lock_en_o, lvl_o}));  // R11
endmodule

// File: rtl/sr_status_guard.sv
module sr_status_guard
  import sr_pkg::*;
#(
  parameter int unsigned AW          = 14,
  parameter logic        RST_LOCK_EN = 1'b0,
  parameter logic [1:0]  RST_LVL     = 2'b00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_pin_ni,
  input  logic          busy_i,
  input  logic          wel_set_i,
  input  logic          wel_clr_i,
  input  logic          wr_done_i,
  input  logic          sr_arm_i,
  input  logic [7:0]    sr_data_i,
  input  logic          sr_commit_i,
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    status_o,
  output logic          sr_wr_ok_o,
  output logic          arr_wr_ok_o
);
  logic      wel;
  logic      lock_en;
  prot_lvl_e lvl;
  logic      hw_locked;
  logic      prot_hit;
  logic      unused_data;

  assign unused_data = ^{sr_data_i[6:4], sr_data_i[1:0]};
  assign hw_locked   = lock_en & ~lock_pin_ni;
  assign sr_wr_ok_o  = wel & ~hw_locked;
  assign arr_wr_ok_o = wel & ~prot_hit;

  sr_wel_latch u_wel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wel_set_i),
    .clr_i  (wel_clr_i),
    .done_i (wr_done_i),
    .hold_i (busy_i),
    .wel_o  (wel)
  );

  sr_cfg_reg #(
    .RST_LOCK_EN (RST_LOCK_EN),
    .RST_LVL     (prot_lvl_e'(RST_LVL))
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (sr_arm_i),
    .hold_i    (busy_i),
    .lock_d_i  (sr_data_i[LOCK_BIT]),
    .lvl_d_i   (prot_lvl_e'(sr_data_i[LVL_HI:LVL_LO])),
    .commit_i  (sr_commit_i),
    .wr_ok_i   (sr_wr_ok_o),
    .locked_i  (hw_locked),
    .lock_en_o (lock_en),
    .lvl_o     (lvl)
  );

  sr_prot_decode #(.AW(AW)) u_dec (
    .lvl_i  (lvl),
    .addr_i (addr_i),
    .hit_o  (prot_hit)
  );

  always_comb begin
    status_o           = 8'h00;
    status_o[LOCK_BIT] = lock_en;
    status_o[LVL_HI:LVL_LO] = lvl;
    status_o[WEL_BIT]  = wel;
    status_o[BUSY_BIT] = busy_i;
  end

  AST_FULL_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[LVL_HI:LVL_LO] == 2'b11 |-> !arr_wr_ok_o);  // R9
  AST_NO_WEL_NO_ARR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[WEL_BIT] |-> !arr_wr_ok_o && !sr_wr_ok_o);  // R10
  AST_PIN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[LOCK_BIT] |-> sr_wr_ok_o == status_o[WEL_BIT]);  // R7
  AST_GAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000);  // R2
endmodule

// File: tb/sr_status_guard_bench.sv
module sr_status_guard_bench;
  localparam int unsigned AW = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lock_pin_ni = 1'b1;
  logic          busy_i = 1'b0;
  logic          wel_set_i = 1'b0;
  logic          wel_clr_i = 1'b0;
  logic          wr_done_i = 1'b0;
  logic          sr_arm_i = 1'b0;
  logic [7:0]    sr_data_i = 8'h00;
  logic          sr_commit_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    status_o;
  logic          sr_wr_ok_o;
  logic          arr_wr_ok_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  sr_status_guard #(.AW(AW)) u_sr_status_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_pin_ni (lock_pin_ni),
    .busy_i      (busy_i),
    .wel_set_i   (wel_set_i),
    .wel_clr_i   (wel_clr_i),
    .wr_done_i   (wr_done_i),
    .sr_arm_i    (sr_arm_i),
    .sr_data_i   (sr_data_i),
    .sr_commit_i (sr_commit_i),
    .addr_i      (addr_i),
    .status_o    (status_o),
    .sr_wr_ok_o  (sr_wr_ok_o),
    .arr_wr_ok_o (arr_wr_ok_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic p_set();
    wel_set_i = 1'b1; step(); wel_set_i = 1'b0;
  endtask

  task automatic p_clr();
    wel_clr_i = 1'b1; step(); wel_clr_i = 1'b0;
  endtask

  task automatic p_done();
    wr_done_i = 1'b1; step(); wr_done_i = 1'b0;
  endtask

  task automatic p_arm(input logic [7:0] d);
    sr_arm_i = 1'b1; sr_data_i = d; step(); sr_arm_i = 1'b0; sr_data_i = 8'h00;
  endtask

  task automatic p_commit();
    sr_commit_i = 1'b1; step(); sr_commit_i = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] d);
    p_set(); p_arm(d); p_commit(); p_done();
  endtask

  task automatic t_reset();
    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset permits", {6'd0, sr_wr_ok_o, arr_wr_ok_o}, 8'h00);
    busy_i = 1'b1; #1;
    chk("R2 busy mirrored", status_o, 8'h01);
    busy_i = 1'b0; #1;
  endtask

  task automatic t_wel();
    p_set();
    chk("R3 set latch", status_o, 8'h02);
    chk("R10 open array ok", {7'd0, arr_wr_ok_o}, 8'h01);
    p_clr();
    chk("R3 clear latch", status_o, 8'h00);
    p_set(); p_done();
    chk("R4 done clears", status_o, 8'h00);
  endtask

  task automatic t_busy();
    busy_i = 1'b1;
    p_set();
    chk("R5 set ignored busy", status_o, 8'h01);
    busy_i = 1'b0; p_set(); busy_i = 1'b1;
    p_clr();
    chk("R5 clear ignored busy", status_o, 8'h03);
    p_done();
    chk("R4 done while busy", status_o, 8'h01);
    p_set(); busy_i = 1'b0; step();
    p_set();
    busy_i = 1'b1; p_arm(8'h0C); busy_i = 1'b0;
    p_commit();
    chk("R5 arm ignored busy", status_o, 8'h02);
    p_clr();
  endtask

  task automatic t_sr_write();
    p_set(); p_commit();
    chk("R11 commit without arm", status_o, 8'h02);
    p_arm(8'hF7); p_commit();
    chk("R6 only bits 7,3,2", status_o, 8'h86);
    p_commit();
    chk("R6 pending consumed", status_o, 8'h86);
    p_done();
    sr_write(8'h00);
    chk("R6 cleared back", status_o, 8'h00);
  endtask

  task automatic t_levels();
    sr_write(8'h04); p_set();
    addr_i = 14'h2FFF; #1; chk("R9 qtr below", {7'd0, arr_wr_ok_o}, 8'h01);
    addr_i = 14'h3000; #1; chk("R9 qtr edge", {7'd0, arr_wr_ok_o}, 8'h00);
    p_clr();
    sr_write(8'h08); p_set();
    addr_i = 14'h1FFF; #1; chk("R9 half below", {7'd0, arr_wr_ok_o}, 8'h01);
    addr_i = 14'h2000; #1; chk("R9 half edge", {7'd0, arr_wr_ok_o}, 8'h00);
    p_clr();
    sr_write(8'h0C); p_set();
    addr_i = 14'h0000; #1; chk("R9 full low", {7'd0, arr_wr_ok_o}, 8'h00);
    p_clr();
    sr_write(8'h00); p_set();
    addr_i = 14'h3FFF; #1; chk("R9 none top", {7'd0, arr_wr_ok_o}, 8'h01);
    p_clr();
    addr_i = '0;
  endtask

  task automatic t_hw_lock();
    lock_pin_ni = 1'b0; p_set(); #1;
    chk("R7 pin ignored lock off", {7'd0, sr_wr_ok_o}, 8'h01);
    lock_pin_ni = 1'b1;
    sr_write(8'h80);
    chk("R6 lock bit set", status_o, 8'h80);
    p_set(); lock_pin_ni = 1'b0; #1;
    chk("R7 locked no sr write", {7'd0, sr_wr_ok_o}, 8'h00);
    addr_i = 14'h3FFF; #1;
    chk("R10 array ok under lock", {7'd0, arr_wr_ok_o}, 8'h01);
    p_arm(8'h0C); p_commit();
    chk("R7 locked commit refused", status_o, 8'h82);
    lock_pin_ni = 1'b1; step();
    p_arm(8'h84); lock_pin_ni = 1'b0; step(); lock_pin_ni = 1'b1; step();
    p_commit();
    chk("R8 abort survives release", status_o, 8'h82);
    p_arm(8'h04); p_commit();
    chk("R6 unlocked commit", status_o, 8'h06);
    p_done(); sr_write(8'h00); addr_i = '0;
  endtask

  task automatic t_collide();
    wel_set_i = 1'b1; wr_done_i = 1'b1; step();
    wel_set_i = 1'b0; wr_done_i = 1'b0;
    chk("R3 done beats set", status_o, 8'h00);
    wel_set_i = 1'b1; wel_clr_i = 1'b1; step();
    wel_set_i = 1'b0; wel_clr_i = 1'b0;
    chk("R3 clear beats set", status_o, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_wel();
    t_busy();
    t_sr_write();
    t_levels();
    t_hw_lock();
    t_collide();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule